// File: doc/BRIEF.md
# Latched Channel-Select Decoder with Break-Before-Make

This block is the digital control for a multi-channel analog switch. A binary channel code passes through an address latch. A latch-open input gates the latch: while it is high the latch follows the code, and while it is low the held code is frozen. The held code is decoded into one-hot switch enables. Two enable inputs of opposite polarity gate those switch enables. An active-low enable and an active-high enable must both be asserted before any switch may close.

A parameter picks the output arrangement. In single-bank mode there is one 8:1 mux with eight switch enables on `a_on`. In dual-bank mode there are two 4:1 banks that share one 2-bit code, so `a_on[3:0]` and `b_on` carry the same one-hot pattern. When the selected channel changes, or when the enables come back after being withdrawn, the outputs are held all-low for `GAP_CYCLES` clocks before the new switch closes. This dead interval gives break-before-make behaviour. The whole block runs in one clock domain with a synchronous reset, and the switch enables come from registers.

Top module: `latched_chan_decoder`

## Requirements
- R1: While `latch_open` is low, the held code does not change. Changes on `sel_in` then have no effect on `a_on` or `b_on`.
- R2: At each clock edge where `latch_open` is high, the held code takes the value of `sel_in`. In dual-bank mode, `sel_in[2]` is replaced by 0. Consecutive different codes are tracked edge by edge.
- R3: The outputs can be non-zero only while `en_n`=0 and `en_p`=1. Any other combination of the two enables forces `a_on` and `b_on` to all-zero from the next clock edge.
- R4: In single-bank mode (`DUAL_BANK`=0), held code k (0..7, with `sel_in[2]` as the most significant bit) drives `a_on` bit k alone, and `b_on` stays 0.
- R5: In dual-bank mode (`DUAL_BANK`=1), held code k (0..3, from `sel_in[1:0]`) drives bit k of both `a_on[3:0]` and `b_on`. `a_on[7:4]` stays 0, and `sel_in[2]` is ignored.
- R6: At most one bit of `a_on` and at most one bit of `b_on` is high in any cycle.
- R7: Consider a channel that is on. At the first edge where the held code differs from it, the outputs go to all-zero. The new channel is driven `GAP_CYCLES` edges later, so no output ever moves directly from one channel to another.
- R8: Count from the first edge at which the enables are valid again, whether after reset, after a disable, or after a disable during a gap. The outputs stay all-zero for `GAP_CYCLES` edges, and then the latest held code is driven.
- R9: A synchronous active-high `rst` clears the held code to 0 and clears `a_on` and `b_on` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_in | input | 3 | Binary channel code |
| latch_open | input | 1 | High: latch follows `sel_in`; low: held code frozen |
| en_n | input | 1 | Active-low enable |
| en_p | input | 1 | Active-high enable |
| a_on | output | 8 | One-hot switch enables, bank A (or the single 8:1 bank) |
| b_on | output | 4 | One-hot switch enables, bank B (dual-bank mode only) |

## Verification
The assertions are checked on every cycle and cover four properties:
- at most one bit is high per bank;
- no output moves directly from one non-zero value to another;
- outputs are off after an invalid enable pair and after reset;
- the held code is frozen while the latch is closed.

Four behaviours need the bench's scenarios, where a cycle-level reference model runs two instances (single-bank with a one-cycle gap, dual-bank with a three-cycle gap):
- the exact code-to-channel mapping in each mode;
- the exact length of the dead interval;
- the restart of the gap when the enables drop mid-gap;
- the masking of the top code bit in dual-bank mode.

// File: rtl/chan_dec_pkg.sv
package chan_dec_pkg;
  localparam int SEL_W = 3;
  localparam int A_W   = 8;
  localparam int B_W   = 4;

  // binary code to one-hot, eight lanes
  function automatic logic [A_W-1:0] onehot8(input logic [SEL_W-1:0] code);
    logic [A_W-1:0] v;
    v = '0;
    v[code] = 1'b1;
    return v;
  endfunction

  // binary code to one-hot, four lanes
  function automatic logic [B_W-1:0] onehot4(input logic [1:0] code);
    logic [B_W-1:0] v;
    v = '0;
    v[code] = 1'b1;
    return v;
  endfunction

  // the part of the code that is meaningful in the chosen mode
  function automatic logic [SEL_W-1:0] mask_code(input logic [SEL_W-1:0] code,
                                                 input bit dual);
    return dual ? {1'b0, code[1:0]} : code;
  endfunction
endpackage

// File: rtl/cd_sel_latch.sv
module cd_sel_latch
  import chan_dec_pkg::*;
#(
  parameter bit DUAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] held_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_o <= '0;
    end else if (open_i) begin
      held_o <= mask_code(sel_i, DUAL);
    end
  end
endmodule

// File: rtl/cd_onehot.sv
module cd_onehot
  import chan_dec_pkg::*;
#(
  parameter bit DUAL = 1'b0
) (
  input  logic [SEL_W-1:0] code_i,
  output logic [A_W-1:0]   a_nxt_o,
  output logic [B_W-1:0]   b_nxt_o
);
  generate
    if (DUAL) begin : g_dual
      always_comb begin
        a_nxt_o = {{(A_W-B_W){1'b0}}, onehot4(code_i[1:0])};
        b_nxt_o = onehot4(code_i[1:0]);
      end
    end else begin : g_single
      always_comb begin
        a_nxt_o = onehot8(code_i);
        b_nxt_o = '0;
      end
    end
  endgenerate
endmodule

// File: rtl/cd_bbm_seq.sv
module cd_bbm_seq
  import chan_dec_pkg::*;
#(
  parameter int GAP_CYCLES = 1,
  parameter int CNT_W      = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_ok_i,
  input  logic [SEL_W-1:0] held_i,
  input  logic [A_W-1:0]   a_nxt_i,
  input  logic [B_W-1:0]   b_nxt_i,
  output logic [A_W-1:0]   a_q,
  output logic [B_W-1:0]   b_q,
  output logic             sel_change_o,
  output logic             turn_on_o
);
  localparam logic [CNT_W-1:0] GAP_FULL = CNT_W'(GAP_CYCLES);
  localparam logic [CNT_W-1:0] GAP_LESS = CNT_W'(GAP_CYCLES - 1);

  logic             on_valid;
  logic [SEL_W-1:0] on_code;
  logic [CNT_W-1:0] gap_left;

  assign sel_change_o = on_valid && (held_i != on_code);
  assign turn_on_o    = en_ok_i && !on_valid && (gap_left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      on_valid <= 1'b0;
      on_code  <= '0;
      gap_left <= GAP_FULL;
      a_q      <= '0;
      b_q      <= '0;
    end else if (!en_ok_i) begin
      on_valid <= 1'b0;
      gap_left <= GAP_FULL;
      a_q      <= '0;
      b_q      <= '0;
    end else if (sel_change_o) begin
      on_valid <= 1'b0;
      gap_left <= GAP_LESS;
      a_q      <= '0;
      b_q      <= '0;
    end else if (turn_on_o) begin
      on_valid <= 1'b1;
      on_code  <= held_i;
      a_q      <= a_nxt_i;
      b_q      <= b_nxt_i;
    end else if (!on_valid) begin
      gap_left <= gap_left - 1'b1;
    end
  end
endmodule

// File: rtl/latched_chan_decoder.sv
module latched_chan_decoder
  import chan_dec_pkg::*;
#(
  parameter bit DUAL_BANK  = 1'b0,
  parameter int GAP_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel_in,
  input  logic       latch_open,
  input  logic       en_n,
  input  logic       en_p,
  output logic [7:0] a_on,
  output logic [3:0] b_on
);
  localparam int CNT_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES + 1);

  logic             en_ok;
  logic [SEL_W-1:0] held_code;
  logic [A_W-1:0]   a_nxt;
  logic [B_W-1:0]   b_nxt;
  logic             sel_change;
  logic             turn_on;

  assign en_ok = !en_n && en_p;

  cd_sel_latch #(.DUAL(DUAL_BANK)) u_latch (
    .clk(clk), .rst(rst), .open_i(latch_open), .sel_i(sel_in), .held_o(held_code)
  );

  cd_onehot #(.DUAL(DUAL_BANK)) u_dec (
    .code_i(held_code), .a_nxt_o(a_nxt), .b_nxt_o(b_nxt)
  );

  cd_bbm_seq #(.GAP_CYCLES(GAP_CYCLES), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .en_ok_i(en_ok), .held_i(held_code),
    .a_nxt_i(a_nxt), .b_nxt_i(b_nxt), .a_q(a_on), .b_q(b_on),
    .sel_change_o(sel_change), .turn_on_o(turn_on)
  );
endmodule

// File: rtl/cd_checker.sv
module cd_checker #(
  parameter bit DUAL = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       latch_open,
  input logic       en_ok,
  input logic       sel_change,
  input logic [2:0] held_code,
  input logic [7:0] a_on,
  input logic [3:0] b_on
);
  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (rst)
    !latch_open |=> $stable(held_code)); // R1
  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_ok |=> (a_on == '0 && b_on == '0)); // R3
  AST_ON_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (a_on != '0) |-> $past(en_ok)); // R3
  AST_ONE_HOT_A: assert property (@(posedge clk) disable iff (rst)
    $onehot0(a_on)); // R6
  AST_ONE_HOT_B: assert property (@(posedge clk) disable iff (rst)
    $onehot0(b_on)); // R6
  AST_BANK_SHAPE: assert property (@(posedge clk) disable iff (rst)
    DUAL ? (b_on == a_on[3:0] && a_on[7:4] == '0) : (b_on == '0)); // R5
  AST_NO_DIRECT_A: assert property (@(posedge clk) disable iff (rst)
    (a_on != '0) |=> (a_on == '0 || $stable(a_on))); // R7
  AST_NO_DIRECT_B: assert property (@(posedge clk) disable iff (rst)
    (b_on != '0) |=> (b_on == '0 || $stable(b_on))); // R7
  AST_CHANGE_OFF: assert property (@(posedge clk) disable iff (rst)
    sel_change |=> (a_on == '0)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (a_on == '0 && b_on == '0 && held_code == '0)); // R9
endmodule

bind latched_chan_decoder cd_checker #(.DUAL(DUAL_BANK)) u_chk (
  .clk(clk), .rst(rst), .latch_open(latch_open), .en_ok(en_ok),
  .sel_change(sel_change), .held_code(held_code), .a_on(a_on), .b_on(b_on)
);

// File: tb/test_latched_chan_decoder.sv
module test_latched_chan_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel_in = '0;
  logic       latch_open = 1'b0;
  logic       en_n = 1'b1;
  logic       en_p = 1'b0;
  logic [7:0] a0, a1;
  logic [3:0] b0, b1;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk; // 125 MHz

  latched_chan_decoder #(.DUAL_BANK(1'b0), .GAP_CYCLES(1)) i_latched_chan_decoder (
    .clk(clk), .rst(rst), .sel_in(sel_in), .latch_open(latch_open),
    .en_n(en_n), .en_p(en_p), .a_on(a0), .b_on(b0));

  latched_chan_decoder #(.DUAL_BANK(1'b1), .GAP_CYCLES(3)) i_latched_chan_decoder_dual (
    .clk(clk), .rst(rst), .sel_in(sel_in), .latch_open(latch_open),
    .en_n(en_n), .en_p(en_p), .a_on(a1), .b_on(b1));

  // reference model state, index 0 = single bank, 1 = dual bank
  bit dual_m [2] = '{1'b0, 1'b1};
  int gap_m  [2] = '{1, 3};
  int held_m [2] = '{0, 0};
  int cur_m  [2] = '{-1, -1};
  int off_m  [2] = '{0, 0};

  typedef struct {
    logic [7:0] ea [2];
    logic [3:0] eb [2];
    string      tag;
  } exp_t;
  exp_t sb_q [$];

  function automatic void expect_of(input int k, output logic [7:0] ea, output logic [3:0] eb);
    ea = '0;
    eb = '0;
    if (cur_m[k] >= 0) begin
      ea[cur_m[k]] = 1'b1;
      if (dual_m[k]) eb[cur_m[k]] = 1'b1;
    end
  endfunction

  task automatic step(input logic [2:0] s, input logic lo, input logic enn,
                      input logic enp, input logic r, input string tag);
    exp_t it;
    @(negedge clk);
    sel_in = s; latch_open = lo; en_n = enn; en_p = enp; rst = r;
    for (int k = 0; k < 2; k++) begin
      int prev_held;
      prev_held = held_m[k];
      if (r) begin
        held_m[k] = 0; cur_m[k] = -1; off_m[k] = 0;
      end else begin
        if (lo) held_m[k] = dual_m[k] ? int'(s[1:0]) : int'(s);
        if (!(!enn && enp)) begin
          cur_m[k] = -1; off_m[k] = 0;
        end else if (cur_m[k] >= 0 && cur_m[k] != prev_held) begin
          cur_m[k] = -1; off_m[k] = 1;
        end else if (cur_m[k] < 0) begin
          if (off_m[k] >= gap_m[k]) cur_m[k] = prev_held;
          else off_m[k]++;
        end
      end
      expect_of(k, it.ea[k], it.eb[k]);
    end
    it.tag = tag;
    @(posedge clk);
    sb_q.push_back(it);
  endtask

  // monitor: compare results away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      checks += 2;
      if (a0 !== it.ea[0] || b0 !== it.eb[0]) begin
        failures++;
        $display("FAIL %s single: a=%b b=%b expected a=%b b=%b", it.tag, a0, b0, it.ea[0], it.eb[0]);
      end
      if (a1 !== it.ea[1] || b1 !== it.eb[1]) begin
        failures++;
        $display("FAIL %s dual: a=%b b=%b expected a=%b b=%b", it.tag, a1, b1, it.ea[1], it.eb[1]);
      end
      checks++;
      if ($countones(a0) > 1 || $countones(a1) > 1 || $countones(b1) > 1) begin
        failures++;
        $display("FAIL R6: a0=%b a1=%b b1=%b expected at most one bit each", a0, a1, b1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) step(3'd5, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
    // R8: start-up gap, channel 0 after the dead interval
    repeat (5) step(3'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    // R4 / R5 / R7: sweep every code, latch closed between loads
    for (int c = 0; c < 8; c++) begin
      step(3'(c), 1'b1, 1'b0, 1'b1, 1'b0, "R4");
      repeat (4) step(3'(c), 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    end
    // R1: latch closed, code wiggles with no effect
    step(3'd2, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    step(3'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    step(3'd4, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    step(3'd6, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    // R3: every invalid enable pair
    repeat (2) step(3'd2, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    repeat (2) step(3'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    repeat (2) step(3'd2, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    // R8: recover with a new code loaded while disabled
    step(3'd5, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    repeat (5) step(3'd5, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    // R8: enables drop in the middle of a gap
    step(3'd1, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    step(3'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    step(3'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
    repeat (6) step(3'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    // R5: codes 6 and 2 differ only in the top bit
    step(3'd6, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
    repeat (5) step(3'd6, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    step(3'd2, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
    repeat (5) step(3'd2, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    // R2: latch open, code changing every edge, then settling
    for (int c = 3; c < 8; c++) step(3'(c), 1'b1, 1'b0, 1'b1, 1'b0, "R2");
    repeat (6) step(3'd7, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
    // R9: reset while a channel is on
    repeat (2) step(3'd3, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
    repeat (6) step(3'd3, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    @(negedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule